// File: doc/BRIEF.md
# Dual Configurable Storage Cell

This block holds two single-bit storage elements that sit side by side in one logic cell. Both elements listen to one shared clock line, one shared clock-enable line, one shared asynchronous set/reset line and a global initialization line. Each element has its own data input and its own output.

Static configuration bits, one set per element, pick three things. The first is whether the element acts on the rising or the falling level of the clock. The second is whether the shared set/reset line drives it to 1 or to 0. The third is whether it behaves as an edge-triggered flip-flop or as a level-sensitive latch.

Two further bits per element say whether the shared enable and set/reset lines are wired to it at all. An unwired enable reads as always active. An unwired set/reset reads as inactive.

The value chosen for set/reset also serves as the element's initial value. That is the value it takes while the global initialization line is high, including at power-up. A chip integrator drives the configuration bits as constants and uses the cell as a building block inside registered logic.

There is no streaming data path here, so no valid/ready handshake is used. All pins are plain control or data levels.

Top module: `dual_store_cell`

## Requirements
- R1: While `gsr` is high, each `q[i]` equals `cfg_sr_sets[i]`. This takes effect at once, with no clock edge needed. It wins over clock, enable, mode and the set/reset line.
- R2: When `cfg_sr_wired[i]` is 1 and `sr` is high, `q[i]` goes to `cfg_sr_sets[i]` at once. It stays there regardless of clock and enable. After `sr` falls, the value is kept until the element's next capture.
- R3: When `cfg_sr_wired[i]` is 0, a high `sr` has no effect on element i.
- R4: In flip-flop mode (`cfg_latch[i]`=0) with `cfg_clk_inv[i]`=0, `q[i]` takes `d[i]` on a rising `clk` edge when the element is enabled. It holds across falling edges.
- R5: In flip-flop mode with `cfg_clk_inv[i]`=1, `q[i]` takes `d[i]` on a falling `clk` edge when enabled. It holds across rising edges.
- R6: With `cfg_ce_wired[i]`=1 and `ce` low, element i keeps its value across clock edges, in both modes.
- R7: With `cfg_ce_wired[i]`=0, element i behaves as if `ce` were high, whatever level `ce` has.
- R8: In latch mode (`cfg_latch[i]`=1), `q[i]` follows `d[i]` while `clk ^ cfg_clk_inv[i]` is 1 and the element is enabled. Otherwise it holds.
- R9: The two elements are independent. Differing configurations of element 0 and element 1 in the same cycle each give their own result. Bit i of every vector port belongs to element i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock line |
| ce | input | 1 | Shared clock enable, active high, synchronous |
| sr | input | 1 | Shared asynchronous set/reset, active high |
| gsr | input | 1 | Global initialization, active high, asynchronous |
| d | input | NUM_ELEM | Data input, one bit per element |
| cfg_clk_inv | input | NUM_ELEM | 1 = element acts on the low clock level or the falling edge |
| cfg_sr_sets | input | NUM_ELEM | 1 = set/reset and init drive the element to 1; 0 = drive it to 0 |
| cfg_latch | input | NUM_ELEM | 1 = latch behaviour; 0 = flip-flop behaviour |
| cfg_ce_wired | input | NUM_ELEM | 0 = enable treated as always active |
| cfg_sr_wired | input | NUM_ELEM | 0 = set/reset treated as inactive |
| q | output | NUM_ELEM | Stored value, one bit per element |

## Verification
Each element holds a single bit, so a wrong internal state shows on `q` at once. The only exception is a flip-flop that is about to recapture: it can hide the error at its next active edge, which comes within half a clock period. A wrong clock polarity or a wrong mode choice appears as `q` changing one half-period early or late. For that reason the bench samples just after both the rising and the falling edge of each cycle. A mis-wired default level for enable or set/reset appears in the first cycle of the vector that leaves the line unwired.

// File: rtl/dse_pkg.sv
package dse_pkg;
  // Per-element static configuration, gathered from the flat top-level pins.
  typedef struct packed {
    logic clk_inv;
    logic sr_sets;
    logic latch_mode;
    logic ce_wired;
    logic sr_wired;
  } elem_cfg_t;

  // Levels substituted for control lines that are not wired to an element.
  localparam logic CE_UNWIRED_LEVEL = 1'b1;
  localparam logic SR_UNWIRED_LEVEL = 1'b0;
endpackage

// File: rtl/dse_ctrl.sv
module dse_ctrl
  import dse_pkg::*;
(
  input  logic      clk,
  input  logic      ce,
  input  logic      sr,
  input  logic      gsr,
  input  elem_cfg_t cfg,
  output logic      ck_eff,
  output logic      en_eff,
  output logic      init_eff,
  output logic      init_val
);
  // Resolve the shared lines into this element's private controls.
  always_comb begin
    ck_eff   = clk ^ cfg.clk_inv;
    en_eff   = cfg.ce_wired ? ce : CE_UNWIRED_LEVEL;
    init_eff = gsr | (cfg.sr_wired ? sr : SR_UNWIRED_LEVEL);
    init_val = cfg.sr_sets;
  end
endmodule

// File: rtl/dse_flop.sv
module dse_flop (
  input  logic ck,
  input  logic en,
  input  logic init,
  input  logic init_val,
  input  logic d,
  output logic q
);
  always_ff @(posedge ck or posedge init) begin
    if (init)    q <= init_val;
    else if (en) q <= d;
  end
endmodule

// File: rtl/dse_latch.sv
module dse_latch (
  input  logic gate,
  input  logic en,
  input  logic init,
  input  logic init_val,
  input  logic d,
  output logic q
);
  always_latch begin
    if (init)            q = init_val;
    else if (gate && en) q = d;
  end
endmodule

// File: rtl/dse_elem.sv
module dse_elem
  import dse_pkg::*;
(
  input  logic      clk,
  input  logic      ce,
  input  logic      sr,
  input  logic      gsr,
  input  elem_cfg_t cfg,
  input  logic      d,
  output logic      q
);
  logic ck_eff, en_eff, init_eff, init_val;
  logic ff_q, lat_q;

  dse_ctrl u_ctrl (
    .clk      (clk),
    .ce       (ce),
    .sr       (sr),
    .gsr      (gsr),
    .cfg      (cfg),
    .ck_eff   (ck_eff),
    .en_eff   (en_eff),
    .init_eff (init_eff),
    .init_val (init_val)
  );

  dse_flop u_flop (
    .ck       (ck_eff),
    .en       (en_eff),
    .init     (init_eff),
    .init_val (init_val),
    .d        (d),
    .q        (ff_q)
  );

  dse_latch u_latch (
    .gate     (ck_eff),
    .en       (en_eff),
    .init     (init_eff),
    .init_val (init_val),
    .d        (d),
    .q        (lat_q)
  );

  assign q = cfg.latch_mode ? lat_q : ff_q;
endmodule

// File: rtl/dual_store_cell.sv
module dual_store_cell
  import dse_pkg::*;
#(
  parameter int NUM_ELEM = 2
) (
  input  logic                clk,
  input  logic                ce,
  input  logic                sr,
  input  logic                gsr,
  input  logic [NUM_ELEM-1:0] d,
  input  logic [NUM_ELEM-1:0] cfg_clk_inv,
  input  logic [NUM_ELEM-1:0] cfg_sr_sets,
  input  logic [NUM_ELEM-1:0] cfg_latch,
  input  logic [NUM_ELEM-1:0] cfg_ce_wired,
  input  logic [NUM_ELEM-1:0] cfg_sr_wired,
  output logic [NUM_ELEM-1:0] q
);
  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_elem
    elem_cfg_t cfg_i;

    assign cfg_i = '{
      clk_inv:    cfg_clk_inv[i],
      sr_sets:    cfg_sr_sets[i],
      latch_mode: cfg_latch[i],
      ce_wired:   cfg_ce_wired[i],
      sr_wired:   cfg_sr_wired[i]
    };

    dse_elem u_elem (
      .clk (clk),
      .ce  (ce),
      .sr  (sr),
      .gsr (gsr),
      .cfg (cfg_i),
      .d   (d[i]),
      .q   (q[i])
    );
  end
endmodule

// File: rtl/dual_store_cell_chk.sv
module dual_store_cell_chk #(
  parameter int NUM_ELEM = 2
) (
  input logic                clk,
  input logic                ce,
  input logic                sr,
  input logic                gsr,
  input logic [NUM_ELEM-1:0] d,
  input logic [NUM_ELEM-1:0] cfg_clk_inv,
  input logic [NUM_ELEM-1:0] cfg_sr_sets,
  input logic [NUM_ELEM-1:0] cfg_latch,
  input logic [NUM_ELEM-1:0] cfg_ce_wired,
  input logic [NUM_ELEM-1:0] cfg_sr_wired,
  input logic [NUM_ELEM-1:0] q
);
  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_chk
    logic ce_ok, init_on, rise_ff;
    assign ce_ok   = ce | ~cfg_ce_wired[i];
    assign init_on = gsr | (sr & cfg_sr_wired[i]);
    assign rise_ff = ~cfg_latch[i] & ~cfg_clk_inv[i];

    always @(negedge clk) begin
      if (gsr) AST_INIT_FORCE: assert (q[i] == cfg_sr_sets[i]) else $error("init value"); // R1
    end

    AST_SR_FORCE: assert property (@(posedge clk) disable iff (gsr)
      (sr && cfg_sr_wired[i]) |-> (q[i] == cfg_sr_sets[i])); // R2

    AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (gsr)
      ($past(rise_ff && ce_ok && !init_on) && rise_ff && !init_on) |-> (q[i] == $past(d[i]))); // R4

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (gsr)
      ($past(rise_ff && cfg_ce_wired[i] && !ce && !init_on) && rise_ff && !init_on)
      |-> (q[i] == $past(q[i]))); // R6

    AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (gsr)
      (cfg_latch[i] && cfg_clk_inv[i] && ce_ok && !init_on) |-> (q[i] == d[i])); // R8
  end
endmodule

bind dual_store_cell dual_store_cell_chk #(.NUM_ELEM(NUM_ELEM)) u_chk (
  .clk          (clk),
  .ce           (ce),
  .sr           (sr),
  .gsr          (gsr),
  .d            (d),
  .cfg_clk_inv  (cfg_clk_inv),
  .cfg_sr_sets  (cfg_sr_sets),
  .cfg_latch    (cfg_latch),
  .cfg_ce_wired (cfg_ce_wired),
  .cfg_sr_wired (cfg_sr_wired),
  .q            (q)
);

// File: tb/dual_store_cell_test.sv
module dual_store_cell_test;
  logic       clk = 1'b0;
  logic       ce, sr, gsr;
  logic [1:0] d, cfg_clk_inv, cfg_sr_sets, cfg_latch, cfg_ce_wired, cfg_sr_wired;
  logic [1:0] q;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  dual_store_cell #(.NUM_ELEM(2)) uut (
    .clk(clk), .ce(ce), .sr(sr), .gsr(gsr), .d(d),
    .cfg_clk_inv(cfg_clk_inv), .cfg_sr_sets(cfg_sr_sets), .cfg_latch(cfg_latch),
    .cfg_ce_wired(cfg_ce_wired), .cfg_sr_wired(cfg_sr_wired), .q(q)
  );

  // {ce, sr, inv, set, latch, ce_wired, sr_wired, d, q after fall, q after rise}
  localparam int NV = 13;
  localparam logic [17:0] VECS [NV] = '{
    18'b1_0_00_00_00_11_11_11_00_11,
    18'b1_0_11_00_00_11_11_11_11_11,
    18'b1_0_10_11_00_11_11_00_01_00,
    18'b0_0_00_01_00_11_11_10_01_01,
    18'b0_0_00_00_00_00_11_11_00_11,
    18'b0_0_00_00_00_10_11_11_00_01,
    18'b1_1_00_10_00_11_11_01_10_10,
    18'b1_1_00_10_00_11_00_01_10_01,
    18'b1_1_00_01_00_11_01_10_01_11,
    18'b1_0_00_00_11_11_11_11_11_11,
    18'b1_0_11_11_11_11_11_00_00_00,
    18'b0_0_01_01_11_11_11_10_01_01,
    18'b1_0_00_00_01_11_11_11_01_11
  };

  function automatic string vec_tag(int k);
    case (k)
      0: return "R4";
      1: return "R5";
      3: return "R6";
      4: return "R7";
      6: return "R2";
      7: return "R3";
      9, 10, 11: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply a configuration while init is held, then release init after the next rise.
  task automatic apply_and_release(logic [17:0] v);
    @(negedge clk); #2;
    gsr = 1'b1;
    ce = v[17]; sr = v[16];
    cfg_clk_inv = v[15:14]; cfg_sr_sets = v[13:12]; cfg_latch = v[11:10];
    cfg_ce_wired = v[9:8]; cfg_sr_wired = v[7:6]; d = v[5:4];
    @(posedge clk); #2;
    gsr = 1'b0;
  endtask

  initial begin
    gsr = 1'b1; sr = 1'b0; ce = 1'b0; d = 2'b00;
    cfg_clk_inv = 2'b00; cfg_sr_sets = 2'b10; cfg_latch = 2'b00;
    cfg_ce_wired = 2'b11; cfg_sr_wired = 2'b11;
    #2;
    check("R1 reset state", q, 2'b10);
    ce = 1'b1; d = 2'b01;
    @(posedge clk); #1;
    check("R1 init overrides clock", q, 2'b10);

    for (int k = 0; k < NV; k++) begin
      apply_and_release(VECS[k]);
      @(negedge clk); #1;
      check(vec_tag(k), q, VECS[k][3:2]);
      @(posedge clk); #1;
      check(vec_tag(k), q, VECS[k][1:0]);
    end

    // Asynchronous set/reset between edges, then capture resumes.
    apply_and_release({1'b1, 1'b0, 2'b00, 2'b01, 2'b00, 2'b11, 2'b11, 2'b10, 4'b0});
    @(negedge clk);
    @(posedge clk); #1;
    check("R4 capture", q, 2'b10);
    #1 sr = 1'b1;
    #1 check("R2 async force", q, 2'b01);
    @(posedge clk); #2 sr = 1'b0;
    @(negedge clk); #1;
    check("R2 kept after release", q, 2'b01);
    @(posedge clk); #1;
    check("R4 recapture", q, 2'b10);

    // Latch transparency and hold inside one phase.
    apply_and_release({1'b1, 1'b0, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 4'b0});
    #1 d = 2'b11;
    #1 check("R8 transparent", q, 2'b11);
    @(negedge clk); #1 d = 2'b00;
    #1 check("R8 opaque hold", q, 2'b11);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule